// File: doc/BRIEF.md
# Bus-Master DMA Request Controller

This block decides, cycle by cycle, whether a bus-master engine should ask for the system bus and in which direction. It keeps one channel for master writes, which move data from the local side onto the bus, and one for master reads, which move data from the bus into the local side. Each channel holds a byte count and a dword address. The block watches how many words wait in the write FIFO and how much room is left in the read FIFO, applies a selectable fill threshold to each, and arbitrates between the two directions under a two-bit priority setting. The bus protocol and the FIFO storage live elsewhere: the FIFOs appear here only as occupancy inputs, and the bus engine reports each finished 4-byte beat on `beat_ack`.

When a beat finishes, the served channel's count drops by four and its address advances by four. The beat that empties a count raises a sticky completion flag, which can drive an interrupt. Two abort events, from the master side and the target side, raise sticky flags of their own. All four flags are cleared by writing ones. Registered FIFO status flags follow the occupancy inputs and can be forced to their empty state.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset both counts are zero, both count-zero outputs are 1, `bus_req` is 0, all four `done_flags` are 0, the write FIFO flags read full=0 empty=1 four=0, and the read FIFO flags read full=0 empty=1 four=1.
- R2: A pulse on `ld_wr` (or `ld_rd`) stores `ld_cnt` as that channel's byte count and `ld_waddr` as its dword address. While that channel is served, `bus_addr` is `{word address, 2'b00}`, so its low two bits are always zero.
- R3: A `beat_ack` while `bus_req` is 1 advances the served channel's address by 4 and lowers its count by 4 in the next cycle. A count of 4 or less becomes 0. The other channel is unchanged.
- R4: A channel can request only while its enable input is 1 and its count is non-zero. Dropping the enable pauses the channel and keeps its count and address, and raising it again resumes from there.
- R5: With its threshold input at 1, the write channel needs `wfifo_words` >= 4, otherwise >= 1. With its threshold input at 1, the read channel needs `rfifo_space` >= 4, otherwise >= 1.
- R6: When both channels are eligible, `{pri_wvr,pri_rvw}` = 01 or 00 serves the write channel and 10 serves the read channel (`bus_wr`=1 means write).
- R7: With `{pri_wvr,pri_rvw}` = 11 and both channels eligible, the channel served is the opposite of the one that received the most recent beat. After reset the write channel goes first. A lone eligible channel is always served.
- R8: The beat that brings a count to zero sets `done_flags[0]` (write) or `done_flags[1]` (read) in the next cycle, and the matching count-zero output reads 1.
- R9: `abort_master` sets `done_flags[2]` and `abort_target` sets `done_flags[3]`. A 1 on bit i of `flag_clr` clears flag i. A set and a clear of the same flag in the same cycle leave the flag set.
- R10: `irq` = (`done_flags[0]` & `ie_wr`) | (`done_flags[1]` & `ie_rd`). The abort flags never raise `irq`.
- R11: The FIFO flags are registered one cycle after the occupancy inputs. Write: full = words == depth, empty = words == 0, four = words >= 4. Read: full = space == 0, empty = space == depth, four = space >= 4.
- R12: `flush_wflags` or `flush_rflags` forces that FIFO's flags to their reset state (from R1) in the next cycle, whatever the occupancy.
- R13: While `bus_req` is 0, `bus_wr` is 0 and `bus_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_wr | input | 1 | Load write channel count and address |
| ld_rd | input | 1 | Load read channel count and address |
| ld_waddr | input | ADDR_W-2 | Dword address to load |
| ld_cnt | input | CNT_W | Byte count to load |
| en_wr | input | 1 | Write channel enable |
| en_rd | input | 1 | Read channel enable |
| thr4_wr | input | 1 | Write threshold select (1: four words) |
| thr4_rd | input | 1 | Read threshold select (1: four free words) |
| pri_wvr | input | 1 | Priority bit, upper |
| pri_rvw | input | 1 | Priority bit, lower |
| wfifo_words | input | LVL_W | Words held in the write FIFO |
| rfifo_space | input | LVL_W | Free words in the read FIFO |
| beat_ack | input | 1 | One 4-byte beat finished for the served channel |
| abort_master | input | 1 | Master-abort event |
| abort_target | input | 1 | Target-abort event |
| flag_clr | input | 4 | Write-one-to-clear for done_flags |
| ie_wr | input | 1 | Interrupt enable, write completion |
| ie_rd | input | 1 | Interrupt enable, read completion |
| flush_wflags | input | 1 | Force write FIFO flags to empty state |
| flush_rflags | input | 1 | Force read FIFO flags to empty state |
| bus_req | output | 1 | Request the bus |
| bus_wr | output | 1 | Served channel is the write channel |
| bus_addr | output | ADDR_W | Byte address of the served channel |
| wr_count | output | CNT_W | Remaining write bytes |
| rd_count | output | CNT_W | Remaining read bytes |
| wr_cnt_zero | output | 1 | Write count is zero |
| rd_cnt_zero | output | 1 | Read count is zero |
| wf_full | output | 1 | Write FIFO full |
| wf_empty | output | 1 | Write FIFO empty |
| wf_four | output | 1 | Write FIFO holds at least four words |
| rf_full | output | 1 | Read FIFO full |
| rf_empty | output | 1 | Read FIFO empty |
| rf_four | output | 1 | Read FIFO has at least four free words |
| done_flags | output | 4 | {target abort, master abort, read done, write done} |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions take for granted that the bus engine reports a beat only while `bus_req` is high, so no beat ever lands on a channel whose count is already zero, and that the FIFO depth is at least four so the thresholds can be met. The stimulus keeps to this by raising `beat_ack` only in cycles where the bench's own model predicts a request. It also keeps occupancy values within the FIFO depth and holds the priority setting steady across the beats whose alternation is being checked.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  localparam int unsigned BEAT_BYTES = 4;
  localparam int unsigned FLG_N      = 4;
  localparam int unsigned FLG_WDONE  = 0;
  localparam int unsigned FLG_RDONE  = 1;
  localparam int unsigned FLG_MABT   = 2;
  localparam int unsigned FLG_TABT   = 3;

  // encoding is {upper priority bit, lower priority bit}
  typedef enum logic [1:0] {
    PRI_DFLT  = 2'b00,
    PRI_WRITE = 2'b01,
    PRI_READ  = 2'b10,
    PRI_ALT   = 2'b11
  } pri_mode_e;

  typedef struct packed {
    logic full;
    logic empty;
    logic four;
  } fifo_flags_t;

  localparam fifo_flags_t WF_CLEAN = '{full: 1'b0, empty: 1'b1, four: 1'b0};
  localparam fifo_flags_t RF_CLEAN = '{full: 1'b0, empty: 1'b1, four: 1'b1};

endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_req_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-3:0] ld_waddr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              beat,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              cnt_zero,
  output logic              done_evt
);
  localparam int unsigned        WA_W   = ADDR_W - 2;
  localparam logic [CNT_W-1:0]   BEAT_B = CNT_W'(BEAT_BYTES);

  logic [WA_W-1:0]  wa_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take_beat;

  // bytes left after one beat; a short tail finishes the channel
  function automatic logic [CNT_W-1:0] cnt_after_beat(input logic [CNT_W-1:0] c);
    return (c > BEAT_B) ? c - BEAT_B : '0;
  endfunction

  assign take_beat = beat && !ld && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wa_q  <= '0;
      cnt_q <= '0;
    end else if (ld) begin
      wa_q  <= ld_waddr;
      cnt_q <= ld_cnt;
    end else if (take_beat) begin
      wa_q  <= wa_q + 1'b1;
      cnt_q <= cnt_after_beat(cnt_q);
    end
  end

  assign addr     = {wa_q, 2'b00};
  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);
  assign done_evt = take_beat && (cnt_after_beat(cnt_q) == '0);

  // R3: a beat is only reported on a channel that still has bytes
  a_r3_beat_live: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> !cnt_zero);

  // R3: a beat moves the address one dword on
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !ld) |=> (addr == $past(addr) + ADDR_W'(BEAT_BYTES)));

  // R4: with no load and no beat the channel holds its place
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !ld) |=> ($stable(cnt) && $stable(addr)));

  // R8: the finishing beat leaves the count at zero
  a_r8_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> cnt_zero);

endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_req_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_rd,
  input  logic             zero_wr,
  input  logic             zero_rd,
  input  logic             thr4_wr,
  input  logic             thr4_rd,
  input  logic [LVL_W-1:0] wwords,
  input  logic [LVL_W-1:0] rspace,
  input  pri_mode_e        mode,
  input  logic             beat,
  output logic             elig_wr,
  output logic             elig_rd,
  output logic             req,
  output logic             sel_wr
);
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_FOUR = LVL_W'(4);

  logic last_wr;
  logic both;
  logic wr_wins;

  function automatic logic level_ok(input logic [LVL_W-1:0] lvl, input logic need4);
    return lvl >= (need4 ? LVL_FOUR : LVL_ONE);
  endfunction

  assign elig_wr = en_wr && !zero_wr && level_ok(wwords, thr4_wr);
  assign elig_rd = en_rd && !zero_rd && level_ok(rspace, thr4_rd);
  assign both    = elig_wr && elig_rd;

  always_comb begin
    unique case (mode)
      PRI_READ: wr_wins = 1'b0;
      PRI_ALT:  wr_wins = !last_wr;
      default:  wr_wins = 1'b1;
    endcase
  end

  assign req    = elig_wr || elig_rd;
  assign sel_wr = elig_wr && (!elig_rd || wr_wins);

  always_ff @(posedge clk) begin
    if (!rst_n)    last_wr <= 1'b0;
    else if (beat) last_wr <= sel_wr;
  end

  // R4: a granted direction is enabled and has bytes left
  a_r4_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (sel_wr ? (en_wr && !zero_wr) : (en_rd && !zero_rd)));

  // R5: a four-word write threshold is honoured
  a_r5_wr_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sel_wr && thr4_wr) |-> (wwords >= LVL_FOUR));

  // R5: a four-word read threshold is honoured
  a_r5_rd_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !sel_wr && thr4_rd) |-> (rspace >= LVL_FOUR));

  // R6: read-first mode never serves write over an eligible read
  a_r6_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PRI_READ && elig_rd) |-> (req && !sel_wr));

  // R6: write-first modes never serve read over an eligible write
  a_r6_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == PRI_WRITE || mode == PRI_DFLT) && elig_wr) |-> sel_wr);

  // R7: back-to-back contested beats in alternate mode swap direction
  a_r7_alt_swaps: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PRI_ALT && both && beat && $past(rst_n && mode == PRI_ALT && both && beat))
      |-> (sel_wr != $past(sel_wr)));

endmodule

// File: rtl/dma_stat.sv
module dma_stat
  import dma_req_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] wwords,
  input  logic [LVL_W-1:0] rspace,
  input  logic             flush_w,
  input  logic             flush_r,
  input  logic [FLG_N-1:0] set_evt,
  input  logic [FLG_N-1:0] clr,
  input  logic             ie_wr,
  input  logic             ie_rd,
  output fifo_flags_t      wf,
  output fifo_flags_t      rf,
  output logic [FLG_N-1:0] flags,
  output logic             irq
);
  localparam logic [LVL_W-1:0] LVL_DEPTH = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_FOUR  = LVL_W'(4);

  fifo_flags_t      wf_q, rf_q;
  logic [FLG_N-1:0] flg_q;

  function automatic fifo_flags_t wr_side(input logic [LVL_W-1:0] words);
    return '{full: (words >= LVL_DEPTH), empty: (words == '0), four: (words >= LVL_FOUR)};
  endfunction

  function automatic fifo_flags_t rd_side(input logic [LVL_W-1:0] space);
    return '{full: (space == '0), empty: (space >= LVL_DEPTH), four: (space >= LVL_FOUR)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wf_q  <= WF_CLEAN;
      rf_q  <= RF_CLEAN;
      flg_q <= '0;
    end else begin
      wf_q  <= flush_w ? WF_CLEAN : wr_side(wwords);
      rf_q  <= flush_r ? RF_CLEAN : rd_side(rspace);
      flg_q <= (flg_q & ~clr) | set_evt;
    end
  end

  assign wf    = wf_q;
  assign rf    = rf_q;
  assign flags = flg_q;
  assign irq   = (flg_q[FLG_WDONE] && ie_wr) || (flg_q[FLG_RDONE] && ie_rd);

  // R9: a set event lands even when the same bit is being cleared
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flags & $past(set_evt)) == $past(set_evt)));

  // R10: an interrupt always has a completion flag behind it
  a_r10_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags[FLG_WDONE] || flags[FLG_RDONE]));

  // R12: a flush leaves both sides in their clean state
  a_r12_flush_w: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |=> (wf == WF_CLEAN));

  a_r12_flush_r: assert property (@(posedge clk) disable iff (!rst_n)
    flush_r |=> (rf == RF_CLEAN));

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 26,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_wr,
  input  logic              ld_rd,
  input  logic [ADDR_W-3:0] ld_waddr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              en_wr,
  input  logic              en_rd,
  input  logic              thr4_wr,
  input  logic              thr4_rd,
  input  logic              pri_wvr,
  input  logic              pri_rvw,
  input  logic [LVL_W-1:0]  wfifo_words,
  input  logic [LVL_W-1:0]  rfifo_space,
  input  logic              beat_ack,
  input  logic              abort_master,
  input  logic              abort_target,
  input  logic [3:0]        flag_clr,
  input  logic              ie_wr,
  input  logic              ie_rd,
  input  logic              flush_wflags,
  input  logic              flush_rflags,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [CNT_W-1:0]  wr_count,
  output logic [CNT_W-1:0]  rd_count,
  output logic              wr_cnt_zero,
  output logic              rd_cnt_zero,
  output logic              wf_full,
  output logic              wf_empty,
  output logic              wf_four,
  output logic              rf_full,
  output logic              rf_empty,
  output logic              rf_four,
  output logic [3:0]        done_flags,
  output logic              irq
);
  localparam int unsigned NCH = 2;  // index 0: write channel, 1: read channel

  logic [NCH-1:0]    ld_v, beat_v, zero_v, done_v;
  logic [ADDR_W-1:0] addr_v [NCH];
  logic [CNT_W-1:0]  cnt_v  [NCH];
  logic              elig_wr, elig_rd, req, sel_wr, beat_live;
  pri_mode_e         mode;
  fifo_flags_t       wf, rf;
  logic [FLG_N-1:0]  set_evt;

  assign mode      = pri_mode_e'({pri_wvr, pri_rvw});
  assign beat_live = beat_ack && req;
  assign ld_v      = {ld_rd, ld_wr};
  assign beat_v    = {beat_live && !sel_wr, beat_live && sel_wr};

  for (genvar d = 0; d < NCH; d++) begin : g_chan
    dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld_v[d]),
      .ld_waddr (ld_waddr),
      .ld_cnt   (ld_cnt),
      .beat     (beat_v[d]),
      .addr     (addr_v[d]),
      .cnt      (cnt_v[d]),
      .cnt_zero (zero_v[d]),
      .done_evt (done_v[d])
    );
  end

  dma_arb #(.LVL_W(LVL_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_wr   (en_wr),
    .en_rd   (en_rd),
    .zero_wr (zero_v[0]),
    .zero_rd (zero_v[1]),
    .thr4_wr (thr4_wr),
    .thr4_rd (thr4_rd),
    .wwords  (wfifo_words),
    .rspace  (rfifo_space),
    .mode    (mode),
    .beat    (beat_live),
    .elig_wr (elig_wr),
    .elig_rd (elig_rd),
    .req     (req),
    .sel_wr  (sel_wr)
  );

  assign set_evt = {abort_target, abort_master, done_v[1], done_v[0]};

  dma_stat #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wwords  (wfifo_words),
    .rspace  (rfifo_space),
    .flush_w (flush_wflags),
    .flush_r (flush_rflags),
    .set_evt (set_evt),
    .clr     (flag_clr),
    .ie_wr   (ie_wr),
    .ie_rd   (ie_rd),
    .wf      (wf),
    .rf      (rf),
    .flags   (done_flags),
    .irq     (irq)
  );

  assign bus_req     = req;
  assign bus_wr      = req && sel_wr;
  assign bus_addr    = !req ? '0 : (sel_wr ? addr_v[0] : addr_v[1]);
  assign wr_count    = cnt_v[0];
  assign rd_count    = cnt_v[1];
  assign wr_cnt_zero = zero_v[0];
  assign rd_cnt_zero = zero_v[1];
  assign {wf_full, wf_empty, wf_four} = wf;
  assign {rf_full, rf_empty, rf_four} = rf;

  // R8: a finishing beat is reflected in the sticky flag one cycle on
  a_r8_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done_v != '0) |=> ((done_flags[1:0] & $past(done_v)) == $past(done_v)));

  // R2: the address presented on the bus is always dword aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr[1:0] == 2'b00));

endmodule

// File: tb/sim_dma_req_ctrl.sv
`timescale 1ns/1ps
module sim_dma_req_ctrl;
  localparam int AW = 32;
  localparam int CW = 26;
  localparam int DEPTH = 16;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ld_wr, ld_rd, en_wr, en_rd, thr4_wr, thr4_rd, pri_wvr, pri_rvw;
  logic [AW-3:0] ld_waddr;
  logic [CW-1:0] ld_cnt;
  logic [LW-1:0] wfifo_words, rfifo_space;
  logic beat_ack, abort_master, abort_target, ie_wr, ie_rd, flush_wflags, flush_rflags;
  logic [3:0] flag_clr;
  logic bus_req, bus_wr, wr_cnt_zero, rd_cnt_zero;
  logic [AW-1:0] bus_addr;
  logic [CW-1:0] wr_count, rd_count;
  logic wf_full, wf_empty, wf_four, rf_full, rf_empty, rf_four, irq;
  logic [3:0] done_flags;

  dma_req_ctrl u0 (.*);

  // staged stimulus, copied onto the pins at a falling edge
  logic s_ldw, s_ldr, s_enw, s_enr, s_tw, s_tr, s_pw, s_pr, s_beat, s_mab, s_tab, s_iw, s_ir, s_fw, s_fr;
  logic [AW-3:0] s_wa;
  logic [CW-1:0] s_cnt;
  int unsigned s_words, s_space;
  logic [3:0] s_clr;

  // bench model state
  logic [CW-1:0] m_cnt [2];
  logic [AW-3:0] m_wa [2];
  logic m_last;
  logic [3:0] m_flg;
  logic [2:0] m_wf, m_rf;

  typedef struct {
    string tag;
    logic req, wr;
    logic [AW-1:0] addr;
    logic [CW-1:0] cw, cr;
    logic [1:0] z;
    logic [2:0] wf, rf;
    logic [3:0] fl;
    logic irq;
  } exp_t;
  exp_t q[$];

  int n_vec = 0;
  int n_bad = 0;

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin m_cnt[k] = '0; m_wa[k] = '0; end
    m_last = 1'b0; m_flg = '0; m_wf = 3'b010; m_rf = 3'b011;
  endtask

  task automatic clear_pulses();
    s_ldw = 0; s_ldr = 0; s_beat = 0; s_mab = 0; s_tab = 0; s_clr = '0; s_fw = 0; s_fr = 0;
  endtask

  task automatic drive_pins();
    ld_wr = s_ldw; ld_rd = s_ldr; ld_waddr = s_wa; ld_cnt = s_cnt;
    en_wr = s_enw; en_rd = s_enr; thr4_wr = s_tw; thr4_rd = s_tr;
    pri_wvr = s_pw; pri_rvw = s_pr; wfifo_words = LW'(s_words); rfifo_space = LW'(s_space);
    beat_ack = s_beat; abort_master = s_mab; abort_target = s_tab; flag_clr = s_clr;
    ie_wr = s_iw; ie_rd = s_ir; flush_wflags = s_fw; flush_rflags = s_fr;
  endtask

  // driver: apply one vector, push the prediction, advance the model
  task automatic step(string tag);
    exp_t e;
    bit okw, okr, pickw, bt;
    int unsigned sv;
    logic [1:0] fin;
    @(negedge clk);
    drive_pins();
    okw = s_enw && (m_cnt[0] != 0) && (s_words >= (s_tw ? 4 : 1));
    okr = s_enr && (m_cnt[1] != 0) && (s_space >= (s_tr ? 4 : 1));
    if (okw && okr) begin
      case ({s_pw, s_pr})
        2'b10: pickw = 0;
        2'b11: pickw = !m_last;
        default: pickw = 1;
      endcase
    end else pickw = okw;
    sv = pickw ? 0 : 1;
    e.tag = tag;
    e.req = okw || okr;
    e.wr = e.req && pickw;
    e.addr = e.req ? {m_wa[sv], 2'b00} : '0;
    e.cw = m_cnt[0]; e.cr = m_cnt[1];
    e.z = {m_cnt[1] == 0, m_cnt[0] == 0};
    e.wf = m_wf; e.rf = m_rf; e.fl = m_flg;
    e.irq = (m_flg[0] && s_iw) || (m_flg[1] && s_ir);
    q.push_back(e);
    bt = s_beat && e.req;
    fin = 2'b00;
    for (int k = 0; k < 2; k++) begin
      if ((k == 0) ? s_ldw : s_ldr) begin
        m_cnt[k] = s_cnt; m_wa[k] = s_wa;
      end else if (bt && sv == k && m_cnt[k] != 0) begin
        m_cnt[k] = (m_cnt[k] > 4) ? m_cnt[k] - 4 : '0;
        m_wa[k] = m_wa[k] + 1;
        if (m_cnt[k] == 0) fin[k] = 1'b1;
      end
    end
    if (bt) m_last = pickw;
    m_flg = (m_flg & ~s_clr) | {s_tab, s_mab, fin};
    m_wf = s_fw ? 3'b010 : {s_words >= DEPTH, s_words == 0, s_words >= 4};
    m_rf = s_fr ? 3'b011 : {s_space == 0, s_space >= DEPTH, s_space >= 4};
    clear_pulses();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    clear_pulses();
    s_enw = 0; s_enr = 0; s_tw = 0; s_tr = 0; s_pw = 0; s_pr = 1; s_iw = 0; s_ir = 0;
    s_wa = '0; s_cnt = '0; s_words = 0; s_space = DEPTH;
    drive_pins();
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1;
  endtask

  function automatic bit fld(string tag, string name, logic [AW-1:0] got, logic [AW-1:0] exp);
    if (got !== exp) begin
      $display("FAIL %s %s: got %0h expected %0h", tag, name, got, exp);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  // monitor: pop each prediction and compare mid-cycle
  initial begin
    forever begin
      @(negedge clk); #5;
      if (q.size() > 0) begin : cmp
        exp_t e;
        bit bad;
        e = q.pop_front();
        bad = 0;
        bad |= fld(e.tag, "bus_req", AW'(bus_req), AW'(e.req));
        bad |= fld(e.tag, "bus_wr", AW'(bus_wr), AW'(e.wr));
        bad |= fld(e.tag, "bus_addr", bus_addr, e.addr);
        bad |= fld(e.tag, "wr_count", AW'(wr_count), AW'(e.cw));
        bad |= fld(e.tag, "rd_count", AW'(rd_count), AW'(e.cr));
        bad |= fld(e.tag, "cnt_zero", AW'({rd_cnt_zero, wr_cnt_zero}), AW'(e.z));
        bad |= fld(e.tag, "wf_flags", AW'({wf_full, wf_empty, wf_four}), AW'(e.wf));
        bad |= fld(e.tag, "rf_flags", AW'({rf_full, rf_empty, rf_four}), AW'(e.rf));
        bad |= fld(e.tag, "done_flags", AW'(done_flags), AW'(e.fl));
        bad |= fld(e.tag, "irq", AW'(irq), AW'(e.irq));
        n_vec++;
        if (bad) n_bad++;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    $display("FAIL watchdog: run hung, got timeout expected completion");
    n_bad++;
    finish_run();
  end

  initial begin
    do_reset();
    step("R1");
    // write channel: load while disabled
    s_ldw = 1; s_wa = 30'h0400_0000; s_cnt = 26'd12; s_words = 1; step("R2");
    step("R4");
    s_enw = 1; step("R2");
    s_tw = 1; s_words = 3; step("R5");
    s_words = 4; step("R5");
    s_beat = 1; step("R3");
    step("R3");
    s_enw = 0; step("R4");
    step("R4");
    s_enw = 1; s_beat = 1; step("R3");
    s_beat = 1; step("R8");
    s_iw = 1; step("R8");
    step("R10");
    // clear completion while a master abort arrives
    s_clr = 4'b0001; s_mab = 1; step("R9");
    step("R9");
    s_clr = 4'b0100; s_tab = 1; step("R9");
    step("R9");
    s_clr = 4'b1000; step("R9");
    // read channel completes while its flag is being cleared
    s_ldr = 1; s_wa = 30'h0000_0C00; s_cnt = 26'd4; s_enr = 1; step("R2");
    s_beat = 1; s_clr = 4'b0010; s_ir = 1; step("R9");
    step("R10");
    s_clr = 4'b0010; step("R9");
    step("R10");
    // fixed priority
    s_ldw = 1; s_wa = 30'h0000_0800; s_cnt = 26'd16; step("R6");
    s_ldr = 1; s_wa = 30'h0000_0C00; s_cnt = 26'd16; step("R6");
    s_pw = 0; s_pr = 0; step("R6");
    s_pw = 0; s_pr = 1; step("R6");
    s_pw = 1; s_pr = 0; step("R6");
    s_beat = 1; step("R6");
    step("R6");
    // alternation from a fresh reset
    do_reset();
    s_ldw = 1; s_wa = 30'h0000_0800; s_cnt = 26'd16; step("R7");
    s_ldr = 1; s_wa = 30'h0000_0C00; s_cnt = 26'd16; step("R7");
    s_enw = 1; s_enr = 1; s_words = 8; s_space = 8; s_pw = 1; s_pr = 1; step("R7");
    for (int i = 0; i < 4; i++) begin s_beat = 1; step("R7"); end
    step("R7");
    s_space = 0; step("R7");
    // read threshold edges with write paused
    s_enw = 0; s_tr = 1; s_space = 3; step("R5");
    s_space = 4; step("R5");
    s_enr = 0; step("R13");
    // FIFO status flags
    s_words = DEPTH; s_space = 0; step("R11");
    step("R11");
    s_words = 2; s_space = 5; step("R11");
    step("R11");
    s_fw = 1; s_fr = 1; s_words = DEPTH; s_space = 0; step("R12");
    step("R12");
    step("R11");
    // short tail on the write channel
    s_ldw = 1; s_wa = 30'h0000_1000; s_cnt = 26'd6; s_enw = 1; s_tw = 0; s_words = 4;
    s_pw = 0; s_pr = 1; step("R3");
    s_beat = 1; step("R3");
    s_beat = 1; step("R3");
    step("R8");
    step("R13");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule